// File: doc/BRIEF.md
# Transmit Link Sequencer for a Serial Converter Lane

This block is the transmit data link layer of one serial converter lane. Each link clock cycle it delivers a four-octet word to the 8b/10b encoder, along with one control-character flag for each octet. After reset, and whenever the receiver requests resynchronization, it sends comma characters. Once the request is released and the local multiframe clock marks a boundary, it sends a four-multiframe alignment sequence. That sequence carries start and end markers and, in its second multiframe, the 14-octet link configuration block. User data follows the alignment sequence directly.

The sequencer does not generate the local multiframe clock. It takes a one-cycle pulse from the clock logic that drives it. It counts the beats of each multiframe itself from the frame size and the frames per multiframe. The receiver's active-low synchronization request is sampled every cycle. The request is honoured in the alignment phase and in the data phase once it has been held low for a full frame.

Top module: `jtx_link_seq`

## Requirements
- R1: From reset, and in every cycle of the comma phase (`phase_o` = 0), all four octets of `pcs_data_o` are 0xBC and `pcs_k_o` is 4'b1111.
- R2: The alignment sequence begins in the cycle after a cycle in which `lmfc_i` is high, `sync_ni` is high, and `sync_ni` has also been high in the preceding cycles so that at least frame size + 9 octets have gone out since release (3 cycles in total at the default frame size of 2). An `lmfc_i` pulse that comes earlier, or release without a pulse, leaves the block in the comma phase.
- R3: The alignment phase (`phase_o` = 1) lasts exactly four multiframes, which is 32 cycles at the defaults (32 octets per multiframe, 8 beats).
- R4: Octet n of a word sits on bits [8n+7:8n] and is sent before octet n+1. Its position within the multiframe is p = 4*beat + n. In every alignment multiframe, position 0 is 0x1C and the last position is 0x7C, both flagged.
- R5: In the second alignment multiframe, position 1 is 0x9C (flagged). Positions 2 to 14 carry configuration octets 0 to 12, unflagged, where configuration octet i is `cfg_i[8i+7:8i]`.
- R6: Position 15 of the second multiframe is the check octet. It equals the sum of configuration octets 0 to 12 modulo 256 and is unflagged.
- R7: Every other alignment position carries the value p modulo 256, unflagged.
- R8: In the cycle after the last alignment beat the block is in the data phase (`phase_o` = 2). In that phase `pcs_data_o` equals `data_i` in the same cycle and `pcs_k_o` is 0.
- R9: If `sync_ni` is low for one frame (one cycle at the default) during the alignment or data phase, the next cycle is in the comma phase. This overrides the move from the alignment phase to the data phase that would happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_ni | input | 1 | Receiver synchronization request, active low |
| lmfc_i | input | 1 | One-cycle pulse ahead of each multiframe boundary |
| data_i | input | 32 | User data word, octet 0 in the low bits |
| cfg_i | input | 104 | Configuration octets 0 to 12 |
| pcs_data_o | output | 32 | Word to the 8b/10b encoder |
| pcs_k_o | output | 4 | Control-character flag for each octet |
| phase_o | output | 2 | 0 comma, 1 alignment, 2 data |

## Verification
The move from the last alignment beat into the data phase and a resynchronization request can land in the same cycle. The bench provokes this by pulling `sync_ni` low exactly on the final alignment beat. It then expects comma output and phase 0 in the next cycle, not user data. A second collision is an `lmfc_i` pulse arriving one cycle before the post-release octet minimum is met. The bench requires that pulse to be ignored and the next pulse, once the minimum is reached, to start the alignment sequence.

// File: rtl/jtx_pkg.sv
`timescale 1ns/1ps
package jtx_pkg;
  typedef enum logic [1:0] {
    PH_CGS  = 2'd0,
    PH_ILAS = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [7:0] CH_COMMA = 8'hBC;
  localparam logic [7:0] CH_START = 8'h1C;
  localparam logic [7:0] CH_END   = 8'h7C;
  localparam logic [7:0] CH_CFG   = 8'h9C;
  localparam int CFG_FIELDS = 13;  // check octet is the 14th
endpackage

// File: rtl/jtx_cfg_csum.sv
`timescale 1ns/1ps
module jtx_cfg_csum #(
  parameter int N_OCT = 13
) (
  input  logic [N_OCT*8-1:0] cfg_i,
  output logic [7:0]         csum_o
);
  always_comb begin
    csum_o = '0;
    for (int i = 0; i < N_OCT; i++) csum_o = csum_o + cfg_i[8*i +: 8];
  end
endmodule

// File: rtl/jtx_sync_ctl.sv
`timescale 1ns/1ps
module jtx_sync_ctl
  import jtx_pkg::*;
#(
  parameter int BEATS_PER_MF  = 8,
  parameter int MIN_CGS_BEATS = 3,
  parameter int RESYNC_BEATS  = 1,
  localparam int BW = (BEATS_PER_MF > 1) ? $clog2(BEATS_PER_MF) : 1,
  localparam int CW = $clog2(MIN_CGS_BEATS + 1),
  localparam int LW = $clog2(RESYNC_BEATS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_ni,
  input  logic          lmfc_i,
  output phase_e        phase_o,
  output logic [1:0]    mf_o,
  output logic [BW-1:0] beat_o
);
  phase_e        phase_q, phase_d;
  logic [1:0]    mf_q, mf_d;
  logic [BW-1:0] beat_q, beat_d;
  logic [CW-1:0] scnt_q, scnt_d;
  logic [LW-1:0] lcnt_q, lcnt_d;

  always_comb begin
    phase_d = phase_q;
    mf_d    = mf_q;
    beat_d  = beat_q;
    scnt_d  = scnt_q;
    lcnt_d  = lcnt_q;
    if (phase_q == PH_CGS) begin
      lcnt_d = '0;
      mf_d   = '0;
      beat_d = '0;
      if (!sync_ni) scnt_d = '0;
      else if (int'(scnt_q) < MIN_CGS_BEATS) scnt_d = scnt_q + CW'(1);
      // current beat counts toward the octet minimum
      if (sync_ni && lmfc_i && (int'(scnt_q) + 1 >= MIN_CGS_BEATS)) phase_d = PH_ILAS;
    end else begin
      if (phase_q == PH_ILAS) begin
        if (int'(beat_q) == BEATS_PER_MF - 1) begin
          beat_d = '0;
          if (mf_q == 2'd3) phase_d = PH_DATA;
          else mf_d = mf_q + 2'd1;
        end else begin
          beat_d = beat_q + BW'(1);
        end
      end
      // resync wins over any phase advance
      if (!sync_ni) begin
        if (int'(lcnt_q) + 1 >= RESYNC_BEATS) begin
          phase_d = PH_CGS;
          scnt_d  = '0;
          lcnt_d  = '0;
          mf_d    = '0;
          beat_d  = '0;
        end else begin
          lcnt_d = lcnt_q + LW'(1);
        end
      end else begin
        lcnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CGS;
      mf_q    <= '0;
      beat_q  <= '0;
      scnt_q  <= '0;
      lcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      mf_q    <= mf_d;
      beat_q  <= beat_d;
      scnt_q  <= scnt_d;
      lcnt_q  <= lcnt_d;
    end
  end

  assign phase_o = phase_q;
  assign mf_o    = mf_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/jtx_octet_mux.sv
`timescale 1ns/1ps
module jtx_octet_mux
  import jtx_pkg::*;
#(
  parameter int MF_OCTETS = 32,
  parameter int BW        = 3
) (
  input  phase_e                  phase_i,
  input  logic [1:0]              mf_i,
  input  logic [BW-1:0]           beat_i,
  input  logic [31:0]             data_i,
  input  logic [CFG_FIELDS*8-1:0] cfg_i,
  input  logic [7:0]              csum_i,
  output logic [31:0]             data_o,
  output logic [3:0]              k_o
);
  for (genvar g = 0; g < 4; g++) begin : g_oct
    logic [7:0] oct;
    logic       kf;
    int         pos;
    always_comb begin
      pos = int'(beat_i) * 4 + g;
      oct = CH_COMMA;
      kf  = 1'b1;
      case (phase_i)
        PH_DATA: begin
          oct = data_i[8*g +: 8];
          kf  = 1'b0;
        end
        PH_ILAS: begin
          if (pos == 0) begin
            oct = CH_START;
          end else if (pos == MF_OCTETS - 1) begin
            oct = CH_END;
          end else if (mf_i == 2'd1 && pos == 1) begin
            oct = CH_CFG;
          end else if (mf_i == 2'd1 && pos >= 2 && pos < 2 + CFG_FIELDS) begin
            oct = cfg_i[8*(pos-2) +: 8];
            kf  = 1'b0;
          end else if (mf_i == 2'd1 && pos == 2 + CFG_FIELDS) begin
            oct = csum_i;
            kf  = 1'b0;
          end else begin
            oct = 8'(pos);
            kf  = 1'b0;
          end
        end
        default: begin
          oct = CH_COMMA;
          kf  = 1'b1;
        end
      endcase
    end
    assign data_o[8*g +: 8] = oct;
    assign k_o[g]           = kf;
  end
endmodule

// File: rtl/jtx_link_seq.sv
`timescale 1ns/1ps
module jtx_link_seq
  import jtx_pkg::*;
#(
  parameter int OCT_PER_FRAME = 2,
  parameter int FRAMES_PER_MF = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_ni,
  input  logic                    lmfc_i,
  input  logic [31:0]             data_i,
  input  logic [CFG_FIELDS*8-1:0] cfg_i,
  output logic [31:0]             pcs_data_o,
  output logic [3:0]              pcs_k_o,
  output logic [1:0]              phase_o
);
  localparam int MF_OCTETS     = OCT_PER_FRAME * FRAMES_PER_MF;
  localparam int BEATS_PER_MF  = MF_OCTETS / 4;
  localparam int MIN_CGS_BEATS = (OCT_PER_FRAME + 9 + 3) / 4;
  localparam int RESYNC_BEATS  = (OCT_PER_FRAME + 3) / 4;
  localparam int BW            = (BEATS_PER_MF > 1) ? $clog2(BEATS_PER_MF) : 1;

  phase_e        phase;
  logic [1:0]    mf;
  logic [BW-1:0] beat;
  logic [7:0]    csum;

  jtx_sync_ctl #(
    .BEATS_PER_MF (BEATS_PER_MF),
    .MIN_CGS_BEATS(MIN_CGS_BEATS),
    .RESYNC_BEATS (RESYNC_BEATS)
  ) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_ni(sync_ni),
    .lmfc_i (lmfc_i),
    .phase_o(phase),
    .mf_o   (mf),
    .beat_o (beat)
  );

  jtx_cfg_csum #(.N_OCT(CFG_FIELDS)) u_csum (
    .cfg_i (cfg_i),
    .csum_o(csum)
  );

  jtx_octet_mux #(.MF_OCTETS(MF_OCTETS), .BW(BW)) u_mux (
    .phase_i(phase),
    .mf_i   (mf),
    .beat_i (beat),
    .data_i (data_i),
    .cfg_i  (cfg_i),
    .csum_i (csum),
    .data_o (pcs_data_o),
    .k_o    (pcs_k_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/jtx_link_seq_chk.sv
`timescale 1ns/1ps
module jtx_link_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sync_ni,
  input logic        lmfc_i,
  input logic [31:0] pcs_data_o,
  input logic [3:0]  pcs_k_o,
  input logic [1:0]  phase_o
);
  AST_CGS_ALL_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |-> (pcs_data_o == 32'hBCBC_BCBC && pcs_k_o == 4'hF)); // R1

  AST_ILAS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1 && $past(phase_o) == 2'd0) |-> ($past(lmfc_i) && $past(sync_ni))); // R2

  AST_ILAS_OPENS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1 && $past(phase_o) == 2'd0) |-> (pcs_data_o[7:0] == 8'h1C && pcs_k_o[0])); // R4

  AST_DATA_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && $past(phase_o) != 2'd2)
      |-> ($past(phase_o) == 2'd1 && $past(pcs_data_o[31:24]) == 8'h7C && $past(pcs_k_o[3]))); // R8

  AST_DATA_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2) |-> (pcs_k_o == 4'h0)); // R8
endmodule

bind jtx_link_seq jtx_link_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_ni   (sync_ni),
  .lmfc_i    (lmfc_i),
  .pcs_data_o(pcs_data_o),
  .pcs_k_o   (pcs_k_o),
  .phase_o   (phase_o)
);

// File: tb/tb_jtx_link_seq.sv
`timescale 1ns/1ps
module tb_jtx_link_seq;
  localparam int MFO = 32;
  localparam int BPM = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_n = 1'b0;
  logic         lmfc = 1'b0;
  logic [31:0]  data = '0;
  logic [103:0] cfg = '0;
  logic [31:0]  pcs_data;
  logic [3:0]   pcs_k;
  logic [1:0]   phase;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  jtx_link_seq dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sync_ni   (sync_n),
    .lmfc_i    (lmfc),
    .data_i    (data),
    .cfg_i     (cfg),
    .pcs_data_o(pcs_data),
    .pcs_k_o   (pcs_k),
    .phase_o   (phase)
  );

  task automatic chk(input logic ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set(input logic s, input logic l, input logic [31:0] d);
    sync_n = s; lmfc = l; data = d;
    #1;
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_cgs(input string tag);
    chk(phase == 2'd0 && pcs_data == 32'hBCBC_BCBC && pcs_k == 4'hF, tag,
        {2'b0, phase, pcs_k, pcs_data}, {2'b0, 2'd0, 4'hF, 32'hBCBC_BCBC});
  endtask

  function automatic logic [8:0] exp_oct(input int mf, input int p);
    logic [7:0] s;
    if (p == 0) return {1'b1, 8'h1C};
    if (p == MFO - 1) return {1'b1, 8'h7C};
    if (mf == 1 && p == 1) return {1'b1, 8'h9C};
    if (mf == 1 && p >= 2 && p <= 14) return {1'b0, cfg[8*(p-2) +: 8]};
    if (mf == 1 && p == 15) begin
      s = '0;
      for (int i = 0; i < 13; i++) s = s + cfg[8*i +: 8];
      return {1'b0, s};
    end
    return {1'b0, 8'(p)};
  endfunction

  function automatic string tag_of(input int mf, input int p);
    if (p == 0 || p == MFO - 1) return "R4";
    if (mf == 1 && p == 15) return "R6";
    if (mf == 1 && p >= 1 && p <= 14) return "R5";
    return "R7";
  endfunction

  // release sync; early lmfc ignored (R2), threshold lmfc accepted
  task automatic t_enter();
    set(1'b1, 1'b0, '0); nxt();
    set(1'b1, 1'b1, '0); nxt();
    chk_cgs("R2 early lmfc ignored");
    set(1'b1, 1'b1, '0); nxt();
    set(1'b1, 1'b0, '0);
    chk(phase == 2'd1, "R2 ilas start", {38'b0, phase}, {38'b0, 2'd1});
  endtask

  // assumes the first ILAS beat is current
  task automatic t_full_ilas();
    for (int mf = 0; mf < 4; mf++) begin
      for (int b = 0; b < BPM; b++) begin
        set(1'b1, 1'b0, 32'hDEAD_0000 + b);
        chk(phase == 2'd1, "R3 ilas phase", {38'b0, phase}, {38'b0, 2'd1});
        for (int n = 0; n < 4; n++) begin
          logic [8:0] e;
          int p;
          p = b * 4 + n;
          e = exp_oct(mf, p);
          chk({pcs_k[n], pcs_data[8*n +: 8]} == e, tag_of(mf, p),
              {31'b0, pcs_k[n], pcs_data[8*n +: 8]}, {31'b0, e});
        end
        nxt();
      end
    end
    set(1'b1, 1'b0, 32'hA5A5_1234);
    chk(phase == 2'd2 && pcs_data == 32'hA5A5_1234 && pcs_k == 4'h0, "R8 first data",
        {2'b0, phase, pcs_k, pcs_data}, {2'b0, 2'd2, 4'h0, 32'hA5A5_1234});
  endtask

  task automatic t_reset();
    set(1'b0, 1'b0, '0);
    chk_cgs("R1 in reset");
    repeat (2) nxt();
    rst_n = 1'b1;
    nxt();
    chk_cgs("R1 after reset");
  endtask

  task automatic t_cgs_hold();
    for (int i = 0; i < 10; i++) begin
      set(1'b0, (i % 4) == 0, 32'h1111_1111);
      nxt();
      chk_cgs("R1 sync held low");
    end
    for (int i = 0; i < 12; i++) begin
      set(1'b1, 1'b0, '0);
      nxt();
      chk_cgs("R2 no lmfc");
    end
    set(1'b0, 1'b0, '0); nxt();
  endtask

  task automatic t_data();
    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hBC1C_7C9C, 32'h1234_5678};
    nxt();
    foreach (pats[i]) begin
      set(1'b1, 1'b0, pats[i]);
      chk(phase == 2'd2 && pcs_data == pats[i] && pcs_k == 4'h0, "R8 data pass",
          {2'b0, phase, pcs_k, pcs_data}, {2'b0, 2'd2, 4'h0, pats[i]});
      nxt();
    end
  endtask

  task automatic t_resync_data();
    set(1'b0, 1'b0, 32'h5555_AAAA); nxt();
    chk_cgs("R9 resync from data");
  endtask

  task automatic t_resync_ilas();
    t_enter();
    for (int i = 0; i < 5; i++) begin set(1'b1, 1'b0, '0); nxt(); end
    set(1'b0, 1'b0, '0); nxt();
    chk_cgs("R9 resync from ilas");
  endtask

  task automatic t_collide();
    set(1'b0, 1'b0, '0); nxt();
    t_enter();
    for (int i = 0; i < 4 * BPM - 1; i++) begin set(1'b1, 1'b0, '0); nxt(); end
    set(1'b1, 1'b0, '0);
    chk(phase == 2'd1 && pcs_data[31:24] == 8'h7C, "R3 last beat",
        {30'b0, phase, pcs_data[31:24]}, {30'b0, 2'd1, 8'h7C});
    set(1'b0, 1'b0, 32'h0F0F_0F0F); nxt();
    chk_cgs("R9 resync beats data entry");
  endtask

  initial begin
    for (int i = 0; i < 13; i++) cfg[8*i +: 8] = 8'(8'h10 + 3 * i);
    cfg[7:0] = 8'hBC;  // comma value as plain data must stay unflagged
    t_reset();
    t_cgs_hold();
    t_enter();
    t_full_ilas();
    t_data();
    t_resync_data();
    t_resync_ilas();
    cfg = {104{1'b1}};  // check octet wraps to 0xF3
    set(1'b0, 1'b0, '0); nxt();
    t_enter();
    t_full_ilas();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule